// File: doc/BRIEF.md
# DRAM bank command timing checker

This block sits beside a memory controller that drives a four-bank double-data-rate SDRAM. Each clock the controller shows it the command it intends to issue: an opcode, a bank number and an auto-precharge flag. The block answers in the same cycle whether the command may go out now. It tracks which banks hold an open row and runs countdown timers for every minimum spacing rule. If the command would break a rule, one registered cycle later it raises a strobe and reports which rule. All spacings are parameters counted in whole clock cycles.

Legal commands advance the tracked state: banks open and close, and timers reload. An illegal command leaves everything unchanged, as if it had never been issued. For each bank, the block also shows whether an ACTIVE, READ, WRITE or PRECHARGE would be legal this cycle. It shows the same for AUTO REFRESH and LOAD MODE, which apply to all banks. A scheduler can use these ready outputs to pick commands without trial and error.

Top module: `bct_checker`

## Requirements
- R1: After reset all banks are closed, no violation is reported, and ACTIVE, PRECHARGE, AUTO REFRESH and LOAD MODE are ready on every bank, while READ and WRITE are not.
- R2: A legal ACTIVE opens its bank. An ACTIVE to a bank that is already open is reported with code 3.
- R3: A READ or WRITE to a closed bank is reported with code 2.
- R4: A READ or WRITE fewer than T_RCD cycles after the ACTIVE of its bank is reported with code 8.
- R5: A PRECHARGE to an open bank fewer than T_RAS cycles after its ACTIVE is reported with code 9. A PRECHARGE to a closed bank is legal and changes nothing.
- R6: An ACTIVE fewer than T_RC cycles after the previous ACTIVE of the same bank is reported with code 6. An ACTIVE fewer than T_RRD cycles after any ACTIVE is reported with code 7.
- R7: A bank closed by PRECHARGE or PRECHARGE-ALL at cycle p may not be activated before p+T_RP (code 5). PRECHARGE-ALL closes every open bank and checks each open bank as a PRECHARGE would.
- R8: A READ or WRITE with auto-precharge closes its bank. The implied precharge occurs T_RDAP cycles after a READ and T_WR2PRE cycles after a WRITE. If that point is fewer than T_RAS cycles after the ACTIVE, the command is refused with code 9. The next ACTIVE needs T_RP cycles after the implied point (code 5).
- R9: AUTO REFRESH and LOAD MODE need all banks closed (code 3) and T_RP elapsed on every bank (code 5). AUTO REFRESH also needs T_RC since every bank's ACTIVE (code 6). ACTIVE, AUTO REFRESH and LOAD MODE within T_RFC cycles of an AUTO REFRESH get code 4. Any command within T_MRD cycles of a LOAD MODE gets code 1.
- R10: A PRECHARGE fewer than T_WR2PRE cycles after a WRITE to its bank gets code 10. A READ fewer than T_WR2RD cycles after any WRITE gets code 11.
- R11: An illegal command changes no bank state or timer. In the cycle after it, viol_strobe is high for one cycle and viol_code holds its code. After a legal command or a NOP both outputs are zero.
- R12: Opcodes are NOP 0, ACTIVE 1, READ 2, WRITE 3, PRECHARGE 4, PRECHARGE-ALL 5, AUTO REFRESH 6, LOAD MODE 7. When several rules fail, the reported code follows this order: 1 (mode spacing), 2 or 3 (bank state), 4, 5, 6, 7, 8, 9, 10, 11.
- R13: Each ready output equals the legality, in the current cycle, of that command without auto-precharge on that bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Opcode, encoding in R12 |
| cmd_bank | input | 2 | Target bank |
| cmd_ap | input | 1 | Auto-precharge flag for READ and WRITE |
| cmd_ok | output | 1 | Presented command is legal now |
| viol_strobe | output | 1 | Previous cycle's command was refused |
| viol_code | output | 4 | Rule broken by the previous cycle's command |
| bank_open | output | 4 | Open-row flag per bank |
| rdy_act | output | 4 | ACTIVE legal per bank |
| rdy_rd | output | 4 | READ legal per bank |
| rdy_wr | output | 4 | WRITE legal per bank |
| rdy_pre | output | 4 | PRECHARGE legal per bank |
| rdy_ref | output | 1 | AUTO REFRESH legal |
| rdy_mrs | output | 1 | LOAD MODE legal |

## Verification
Some properties are checked on every cycle. A refused command freezes the open-bank flags. The strobe follows every refusal and carries a nonzero code. Legal READ, WRITE, REFRESH and LOAD MODE match the bank-state preconditions. Each ACTIVE presented agrees with its ready bit. Auto-precharge always leaves its bank closed with a precharge timer running. The exact spacing limits can only be shown by the bench's scenarios, which are replayed against a reference model built on timestamps. These cover each spacing just below and at its limit, the priority between rules that fail together, and the implied precharge point for both READ and WRITE.

// File: rtl/bct_pkg.sv
package bct_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ACT  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_PRE  = 3'd4,
        OP_PREA = 3'd5,
        OP_REF  = 3'd6,
        OP_MRS  = 3'd7
    } op_e;

    typedef enum logic [3:0] {
        V_NONE   = 4'd0,
        V_MRD    = 4'd1,
        V_CLOSED = 4'd2,
        V_OPEN   = 4'd3,
        V_RFC    = 4'd4,
        V_RP     = 4'd5,
        V_RC     = 4'd6,
        V_RRD    = 4'd7,
        V_RCD    = 4'd8,
        V_RAS    = 4'd9,
        V_WR     = 4'd10,
        V_WTR    = 4'd11
    } viol_e;

    // readiness flags a bank tracker exports; each is "spacing satisfied"
    typedef struct packed {
        logic open;
        logic rcd_ok;
        logic ras_ok;
        logic ras_rdap_ok;
        logic ras_wrap_ok;
        logic rc_ok;
        logic rp_ok;
        logic wr_ok;
    } bank_flags_t;

    typedef struct packed {
        logic rrd_ok;
        logic rfc_ok;
        logic mrd_ok;
        logic wtr_ok;
    } glob_flags_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bct_bank.sv
module bct_bank
    import bct_pkg::*;
#(
    parameter int CW       = 5,
    parameter int T_RCD    = 3,
    parameter int T_RAS    = 6,
    parameter int T_RC     = 9,
    parameter int T_RP     = 3,
    parameter int T_RDAP   = 2,
    parameter int T_WR2PRE = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go_act,
    input  logic        go_pre,
    input  logic        go_rd_ap,
    input  logic        go_wr,
    input  logic        go_wr_ap,
    output bank_flags_t flags
);

    localparam logic [CW-1:0] L_RCD   = CW'(T_RCD - 1);
    localparam logic [CW-1:0] L_RAS   = CW'(T_RAS - 1);
    localparam logic [CW-1:0] L_RC    = CW'(T_RC - 1);
    localparam logic [CW-1:0] L_RP    = CW'(T_RP - 1);
    localparam logic [CW-1:0] L_RDAP  = CW'(T_RDAP + T_RP - 1);
    localparam logic [CW-1:0] L_WRAP  = CW'(T_WR2PRE + T_RP - 1);
    localparam logic [CW-1:0] L_WR    = CW'(T_WR2PRE - 1);
    localparam logic [CW-1:0] OFF_RD  = CW'(T_RDAP);
    localparam logic [CW-1:0] OFF_WR  = CW'(T_WR2PRE);

    typedef struct packed {
        logic          open;
        logic [CW-1:0] rcd;
        logic [CW-1:0] ras;
        logic [CW-1:0] rc;
        logic [CW-1:0] rp;
        logic [CW-1:0] wr;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [CW-1:0] tick(input logic [CW-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.rcd  = tick(st_q.rcd);
        st_d.ras  = tick(st_q.ras);
        st_d.rc   = tick(st_q.rc);
        st_d.rp   = tick(st_q.rp);
        st_d.wr   = tick(st_q.wr);
        if (go_act) begin
            st_d.open = 1'b1;
            st_d.rcd  = L_RCD;
            st_d.ras  = L_RAS;
            st_d.rc   = L_RC;
        end
        if (go_pre && st_q.open) begin
            st_d.open = 1'b0;
            st_d.rp   = L_RP;
        end
        if (go_rd_ap) begin
            st_d.open = 1'b0;
            st_d.rp   = L_RDAP;
        end
        if (go_wr) begin
            st_d.wr = L_WR;
        end
        if (go_wr_ap) begin
            st_d.open = 1'b0;
            st_d.rp   = L_WRAP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        flags.open        = st_q.open;
        flags.rcd_ok      = (st_q.rcd == '0);
        flags.ras_ok      = (st_q.ras == '0);
        flags.ras_rdap_ok = (st_q.ras <= OFF_RD);
        flags.ras_wrap_ok = (st_q.ras <= OFF_WR);
        flags.rc_ok       = (st_q.rc == '0);
        flags.rp_ok       = (st_q.rp == '0);
        flags.wr_ok       = (st_q.wr == '0);
    end

    // R2: an accepted ACTIVE leaves the bank open
    p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        go_act |=> flags.open);

    // R4: the column delay never outlasts the row-active minimum
    p_rcd_within_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rcd <= st_q.ras);

    // R8: auto-precharge closes the bank and starts a precharge wait
    p_ap_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (go_rd_ap || go_wr_ap) |=> (!flags.open && !flags.rp_ok));

endmodule

// File: rtl/bct_glob.sv
module bct_glob
    import bct_pkg::*;
#(
    parameter int CW      = 5,
    parameter int T_RRD   = 2,
    parameter int T_RFC   = 10,
    parameter int T_MRD   = 2,
    parameter int T_WR2RD = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go_act,
    input  logic        go_ref,
    input  logic        go_mrs,
    input  logic        go_wr,
    output glob_flags_t flags
);

    localparam logic [CW-1:0] L_RRD = CW'(T_RRD - 1);
    localparam logic [CW-1:0] L_RFC = CW'(T_RFC - 1);
    localparam logic [CW-1:0] L_MRD = CW'(T_MRD - 1);
    localparam logic [CW-1:0] L_WTR = CW'(T_WR2RD - 1);

    typedef struct packed {
        logic [CW-1:0] rrd;
        logic [CW-1:0] rfc;
        logic [CW-1:0] mrd;
        logic [CW-1:0] wtr;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [CW-1:0] tick(input logic [CW-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

    always_comb begin
        st_d.rrd = go_act ? L_RRD : tick(st_q.rrd);
        st_d.rfc = go_ref ? L_RFC : tick(st_q.rfc);
        st_d.mrd = go_mrs ? L_MRD : tick(st_q.mrd);
        st_d.wtr = go_wr  ? L_WTR : tick(st_q.wtr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        flags.rrd_ok = (st_q.rrd == '0);
        flags.rfc_ok = (st_q.rfc == '0);
        flags.mrd_ok = (st_q.mrd == '0);
        flags.wtr_ok = (st_q.wtr == '0);
    end

    if (T_RFC > 1) begin : g_rfc_chk
        // R9: the cycle after a refresh, the refresh spacing is still pending
        p_rfc_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
            go_ref |=> !flags.rfc_ok);
    end

endmodule

// File: rtl/bct_judge.sv
module bct_judge
    import bct_pkg::*;
#(
    parameter int NB = 4,
    parameter int BW = 2
) (
    input  op_e                    op,
    input  logic [BW-1:0]          bank,
    input  logic                   ap,
    input  bank_flags_t [NB-1:0]   bflags,
    input  glob_flags_t            gflags,
    output viol_e                  code
);

    bank_flags_t b;
    logic any_open, all_rp, all_rc, prea_ras, prea_wr, ras_ap;

    always_comb begin
        b        = bflags[bank];
        any_open = 1'b0;
        all_rp   = 1'b1;
        all_rc   = 1'b1;
        prea_ras = 1'b1;
        prea_wr  = 1'b1;
        for (int i = 0; i < NB; i++) begin
            any_open = any_open | bflags[i].open;
            all_rp   = all_rp & bflags[i].rp_ok;
            all_rc   = all_rc & bflags[i].rc_ok;
            if (bflags[i].open) begin
                prea_ras = prea_ras & bflags[i].ras_ok;
                prea_wr  = prea_wr & bflags[i].wr_ok;
            end
        end
        ras_ap = (op == OP_RD) ? b.ras_rdap_ok : b.ras_wrap_ok;

        code = V_NONE;
        if (op != OP_NOP && !gflags.mrd_ok) begin
            code = V_MRD;
        end else begin
            case (op)
                OP_ACT: begin
                    if (b.open)                code = V_OPEN;
                    else if (!gflags.rfc_ok)   code = V_RFC;
                    else if (!b.rp_ok)         code = V_RP;
                    else if (!b.rc_ok)         code = V_RC;
                    else if (!gflags.rrd_ok)   code = V_RRD;
                end
                OP_RD, OP_WR: begin
                    if (!b.open)               code = V_CLOSED;
                    else if (!b.rcd_ok)        code = V_RCD;
                    else if (ap && !ras_ap)    code = V_RAS;
                    else if (op == OP_RD && !gflags.wtr_ok) code = V_WTR;
                end
                OP_PRE: begin
                    if (b.open && !b.ras_ok)      code = V_RAS;
                    else if (b.open && !b.wr_ok)  code = V_WR;
                end
                OP_PREA: begin
                    if (!prea_ras)             code = V_RAS;
                    else if (!prea_wr)         code = V_WR;
                end
                OP_REF: begin
                    if (any_open)              code = V_OPEN;
                    else if (!gflags.rfc_ok)   code = V_RFC;
                    else if (!all_rp)          code = V_RP;
                    else if (!all_rc)          code = V_RC;
                end
                OP_MRS: begin
                    if (any_open)              code = V_OPEN;
                    else if (!gflags.rfc_ok)   code = V_RFC;
                    else if (!all_rp)          code = V_RP;
                end
                default: code = V_NONE;
            endcase
        end
    end

endmodule

// File: rtl/bct_checker.sv
module bct_checker
    import bct_pkg::*;
#(
    parameter int NB       = 4,
    parameter int T_RCD    = 3,
    parameter int T_RAS    = 6,
    parameter int T_RC     = 9,
    parameter int T_RRD    = 2,
    parameter int T_RP     = 3,
    parameter int T_RFC    = 10,
    parameter int T_MRD    = 2,
    parameter int T_WR2PRE = 5,
    parameter int T_WR2RD  = 4,
    parameter int T_RDAP   = 2,
    localparam int BW      = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [BW-1:0] cmd_bank,
    input  logic          cmd_ap,
    output logic          cmd_ok,
    output logic          viol_strobe,
    output logic [3:0]    viol_code,
    output logic [NB-1:0] bank_open,
    output logic [NB-1:0] rdy_act,
    output logic [NB-1:0] rdy_rd,
    output logic [NB-1:0] rdy_wr,
    output logic [NB-1:0] rdy_pre,
    output logic          rdy_ref,
    output logic          rdy_mrs
);

    localparam int MAXT = imax(imax(imax(T_RC, T_RFC), T_RDAP + T_RP),
                               imax(T_WR2PRE + T_RP, imax(T_WR2RD, T_MRD)));
    localparam int CW   = $clog2(MAXT + 1);

    typedef struct packed {
        logic  err;
        viol_e code;
    } rep_t;

    op_e                  op_w;
    viol_e                main_code;
    logic                 legal;
    bank_flags_t [NB-1:0] bflags;
    glob_flags_t          gflags;
    rep_t                 rep_d, rep_q;

    assign op_w  = cmd_valid ? op_e'(cmd_op) : OP_NOP;
    assign legal = (main_code == V_NONE);

    bct_judge #(.NB(NB), .BW(BW)) u_main (
        .op(op_w), .bank(cmd_bank), .ap(cmd_ap),
        .bflags(bflags), .gflags(gflags), .code(main_code)
    );

    for (genvar i = 0; i < NB; i++) begin : g_bank
        logic hit;
        assign hit = legal && (cmd_bank == BW'(i));

        bct_bank #(
            .CW(CW), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC),
            .T_RP(T_RP), .T_RDAP(T_RDAP), .T_WR2PRE(T_WR2PRE)
        ) u_bank (
            .clk(clk), .rst_n(rst_n),
            .go_act  (hit && op_w == OP_ACT),
            .go_pre  ((hit && op_w == OP_PRE) || (legal && op_w == OP_PREA)),
            .go_rd_ap(hit && op_w == OP_RD && cmd_ap),
            .go_wr   (hit && op_w == OP_WR),
            .go_wr_ap(hit && op_w == OP_WR && cmd_ap),
            .flags   (bflags[i])
        );

        viol_e c_act, c_rd, c_wr, c_pre;
        bct_judge #(.NB(NB), .BW(BW)) u_p_act (.op(OP_ACT), .bank(BW'(i)), .ap(1'b0),
            .bflags(bflags), .gflags(gflags), .code(c_act));
        bct_judge #(.NB(NB), .BW(BW)) u_p_rd (.op(OP_RD), .bank(BW'(i)), .ap(1'b0),
            .bflags(bflags), .gflags(gflags), .code(c_rd));
        bct_judge #(.NB(NB), .BW(BW)) u_p_wr (.op(OP_WR), .bank(BW'(i)), .ap(1'b0),
            .bflags(bflags), .gflags(gflags), .code(c_wr));
        bct_judge #(.NB(NB), .BW(BW)) u_p_pre (.op(OP_PRE), .bank(BW'(i)), .ap(1'b0),
            .bflags(bflags), .gflags(gflags), .code(c_pre));

        assign rdy_act[i]   = (c_act == V_NONE);
        assign rdy_rd[i]    = (c_rd == V_NONE);
        assign rdy_wr[i]    = (c_wr == V_NONE);
        assign rdy_pre[i]   = (c_pre == V_NONE);
        assign bank_open[i] = bflags[i].open;
    end

    viol_e c_ref, c_mrs;
    bct_judge #(.NB(NB), .BW(BW)) u_p_ref (.op(OP_REF), .bank('0), .ap(1'b0),
        .bflags(bflags), .gflags(gflags), .code(c_ref));
    bct_judge #(.NB(NB), .BW(BW)) u_p_mrs (.op(OP_MRS), .bank('0), .ap(1'b0),
        .bflags(bflags), .gflags(gflags), .code(c_mrs));
    assign rdy_ref = (c_ref == V_NONE);
    assign rdy_mrs = (c_mrs == V_NONE);

    bct_glob #(
        .CW(CW), .T_RRD(T_RRD), .T_RFC(T_RFC), .T_MRD(T_MRD), .T_WR2RD(T_WR2RD)
    ) u_glob (
        .clk(clk), .rst_n(rst_n),
        .go_act(legal && op_w == OP_ACT),
        .go_ref(legal && op_w == OP_REF),
        .go_mrs(legal && op_w == OP_MRS),
        .go_wr (legal && op_w == OP_WR),
        .flags (gflags)
    );

    always_comb begin
        rep_d.err  = !legal;
        rep_d.code = main_code;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_q <= '{err: 1'b0, code: V_NONE};
        end else begin
            rep_q <= rep_d;
        end
    end

    assign cmd_ok      = legal;
    assign viol_strobe = rep_q.err;
    assign viol_code   = rep_q.code;

    // R11: a refused command leaves every bank's open state untouched
    p_refused_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op != 3'd0 && !cmd_ok) |=> $stable(bank_open));

    // R11: a refusal is followed by the strobe and its code
    p_refusal_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op != 3'd0 && !cmd_ok) |=> (viol_strobe && viol_code == $past(main_code)));

    // R11: strobe and code agree
    p_strobe_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        viol_strobe == (viol_code != 4'd0));

    // R3: a legal column command targets an open bank
    p_col_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ok && (cmd_op == 3'd2 || cmd_op == 3'd3)) |-> bank_open[cmd_bank]);

    // R9: refresh and mode load are accepted only with every bank closed
    p_all_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ok && (cmd_op == 3'd6 || cmd_op == 3'd7)) |-> (bank_open == '0));

    // R13: the ACTIVE ready bit agrees with the verdict on a presented ACTIVE
    p_ready_act_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1) |-> (cmd_ok == rdy_act[cmd_bank]));

endmodule

// File: tb/bct_checker_bench.sv
module bct_checker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int T_RCD = 3, T_RAS = 6, T_RC = 9, T_RRD = 2, T_RP = 3;
    localparam int T_RFC = 10, T_MRD = 2, T_WR2PRE = 5, T_WR2RD = 4, T_RDAP = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [1:0] cmd_bank = 2'd0;
    logic cmd_ap = 1'b0;
    logic cmd_ok, viol_strobe, rdy_ref, rdy_mrs;
    logic [3:0] viol_code;
    logic [NB-1:0] bank_open, rdy_act, rdy_rd, rdy_wr, rdy_pre;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bct_checker u_bct_checker (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .cmd_ok(cmd_ok),
        .viol_strobe(viol_strobe), .viol_code(viol_code), .bank_open(bank_open),
        .rdy_act(rdy_act), .rdy_rd(rdy_rd), .rdy_wr(rdy_wr), .rdy_pre(rdy_pre),
        .rdy_ref(rdy_ref), .rdy_mrs(rdy_mrs)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // timestamp reference model
    int now = 0;
    bit open_m[NB];
    int t_act[NB], t_pe[NB], t_wr[NB];
    int t_la = -1000, t_ref = -1000, t_mrs = -1000, t_wa = -1000;
    int pend = 0;
    string ptag = "R11";

    task automatic chk(input int act, input int exp, input string tag);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, now, act, exp);
        end
    endtask

    function automatic int eval(input int op, input int b, input bit ap);
        bit anyo = 0;
        int off;
        for (int i = 0; i < NB; i++) anyo |= open_m[i];
        if (op == 0) return 0;
        if (now - t_mrs < T_MRD) return 1;
        case (op)
            1: begin
                if (open_m[b]) return 3;
                if (now - t_ref < T_RFC) return 4;
                if (now - t_pe[b] < T_RP) return 5;
                if (now - t_act[b] < T_RC) return 6;
                if (now - t_la < T_RRD) return 7;
            end
            2, 3: begin
                if (!open_m[b]) return 2;
                if (now - t_act[b] < T_RCD) return 8;
                if (ap) begin
                    off = (op == 2) ? T_RDAP : T_WR2PRE;
                    if (now + off - t_act[b] < T_RAS) return 9;
                end
                if (op == 2 && now - t_wa < T_WR2RD) return 11;
            end
            4: begin
                if (open_m[b] && now - t_act[b] < T_RAS) return 9;
                if (open_m[b] && now - t_wr[b] < T_WR2PRE) return 10;
            end
            5: begin
                for (int i = 0; i < NB; i++)
                    if (open_m[i] && now - t_act[i] < T_RAS) return 9;
                for (int i = 0; i < NB; i++)
                    if (open_m[i] && now - t_wr[i] < T_WR2PRE) return 10;
            end
            6, 7: begin
                if (anyo) return 3;
                if (now - t_ref < T_RFC) return 4;
                for (int i = 0; i < NB; i++) if (now - t_pe[i] < T_RP) return 5;
                if (op == 6)
                    for (int i = 0; i < NB; i++) if (now - t_act[i] < T_RC) return 6;
            end
            default: return 0;
        endcase
        return 0;
    endfunction

    task automatic apply(input int op, input int b, input bit ap);
        case (op)
            1: begin open_m[b] = 1; t_act[b] = now; t_la = now; end
            2: if (ap) begin open_m[b] = 0; t_pe[b] = now + T_RDAP; end
            3: begin
                t_wr[b] = now; t_wa = now;
                if (ap) begin open_m[b] = 0; t_pe[b] = now + T_WR2PRE; end
            end
            4: if (open_m[b]) begin open_m[b] = 0; t_pe[b] = now; end
            5: for (int i = 0; i < NB; i++)
                   if (open_m[i]) begin open_m[i] = 0; t_pe[i] = now; end
            6: t_ref = now;
            7: t_mrs = now;
            default: ;
        endcase
    endtask

    // one command cycle; want >= 0 gives a directed expected code
    task automatic step(input int op, input int b, input bit ap, input int want, input string tag);
        int exp;
        @(negedge clk);
        chk(int'(viol_strobe), (pend != 0) ? 1 : 0, {ptag, " strobe (R11)"});
        chk(int'(viol_code), pend, {ptag, " code (R12)"});
        for (int i = 0; i < NB; i++)
            chk(int'(bank_open[i]), int'(open_m[i]), "R11 R2 bank_open");
        cmd_valid = 1'b1;
        cmd_op    = op[2:0];
        cmd_bank  = b[1:0];
        cmd_ap    = ap;
        #1;
        exp = (want >= 0) ? want : eval(op, b, ap);
        chk(int'(cmd_ok), (exp == 0) ? 1 : 0, {tag, " cmd_ok"});
        for (int i = 0; i < NB; i++) begin
            chk(int'(rdy_act[i]), (eval(1, i, 0) == 0) ? 1 : 0, "R13 rdy_act");
            chk(int'(rdy_rd[i]),  (eval(2, i, 0) == 0) ? 1 : 0, "R13 rdy_rd");
            chk(int'(rdy_wr[i]),  (eval(3, i, 0) == 0) ? 1 : 0, "R13 rdy_wr");
            chk(int'(rdy_pre[i]), (eval(4, i, 0) == 0) ? 1 : 0, "R13 rdy_pre");
        end
        chk(int'(rdy_ref), (eval(6, 0, 0) == 0) ? 1 : 0, "R13 rdy_ref");
        chk(int'(rdy_mrs), (eval(7, 0, 0) == 0) ? 1 : 0, "R13 rdy_mrs");
        pend = exp;
        ptag = tag;
        @(posedge clk);
        if (exp == 0) apply(op, b, ap);
        now++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, "R11");
    endtask

    initial begin
        for (int i = 0; i < NB; i++) begin
            open_m[i] = 0; t_act[i] = -1000; t_pe[i] = -1000; t_wr[i] = -1000;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(int'(bank_open), 0, "R1 bank_open");
        chk(int'(viol_strobe), 0, "R1 strobe");
        chk(int'(rdy_act), 15, "R1 rdy_act");
        chk(int'(rdy_pre), 15, "R1 rdy_pre");
        chk(int'(rdy_rd), 0, "R1 rdy_rd");
        chk(int'(rdy_wr), 0, "R1 rdy_wr");
        chk(int'(rdy_ref), 1, "R1 rdy_ref");
        chk(int'(rdy_mrs), 1, "R1 rdy_mrs");

        // directed corner cases (cycle numbers in comments)
        step(1, 0, 0, 0,  "R2");          // 0 ACT b0
        step(1, 1, 0, 7,  "R6");          // 1 ACT b1 too soon after b0
        step(2, 0, 0, 8,  "R4");          // 2 READ below column delay
        step(2, 0, 0, 0,  "R4");          // 3 READ at the limit
        step(4, 0, 0, 9,  "R5");          // 4 PRE before row-active minimum
        step(1, 0, 0, 3,  "R2");          // 5 ACT to open bank
        step(4, 0, 0, 0,  "R5");          // 6 PRE at the limit
        step(1, 0, 0, 5,  "R7");          // 7 ACT during precharge (beats row cycle)
        step(2, 2, 0, 2,  "R3");          // 8 READ to closed bank
        step(6, 0, 0, 0,  "R9");          // 9 REFRESH, all closed
        step(1, 3, 0, 4,  "R9");          // 10 ACT during refresh
        step(7, 0, 0, 4,  "R9");          // 11 MODE during refresh
        idle(7);                          // 12..18
        step(7, 0, 0, 0,  "R9");          // 19 MODE at refresh limit
        step(1, 0, 0, 1,  "R9");          // 20 ACT right after MODE
        step(1, 0, 0, 0,  "R6");          // 21 ACT b0
        step(3, 0, 0, 8,  "R4");          // 22 WRITE too early
        idle(1);                          // 23
        step(3, 0, 0, 0,  "R4");          // 24 WRITE
        step(2, 0, 0, 11, "R10");         // 25 READ inside write-to-read gap
        step(4, 0, 0, 9,  "R5");          // 26 PRE before row-active minimum
        step(4, 0, 0, 10, "R10");         // 27 PRE inside write recovery
        step(2, 0, 1, 0,  "R8");          // 28 READ with auto-precharge
        step(2, 0, 0, 2,  "R8");          // 29 bank closed by it
        step(1, 0, 0, 5,  "R8");          // 30 ACT at the implied precharge point
        idle(2);                          // 31, 32
        step(1, 0, 0, 0,  "R8");          // 33 ACT after implied precharge wait
        idle(1);                          // 34
        step(1, 1, 0, 0,  "R6");          // 35 ACT b1 at cross-bank limit
        idle(2);                          // 36, 37
        step(2, 1, 1, 9,  "R8");          // 38 READ-AP precharging too early
        step(3, 1, 1, 0,  "R8");          // 39 WRITE-AP accepted
        step(5, 0, 0, 0,  "R7");          // 40 PRECHARGE-ALL
        idle(1);                          // 41
        step(1, 1, 0, 5,  "R8");          // 42 b1 still inside implied precharge
        step(1, 0, 0, 0,  "R7");          // 43 b0 after precharge-all wait
        idle(12);

        // constrained random traffic against the model
        void'($urandom(32'd20240917));
        for (int i = 0; i < 3000; i++) begin
            int op, b;
            bit ap;
            op = ($urandom % 10 < 4) ? 0 : 1 + int'($urandom % 7);
            b  = int'($urandom % NB);
            ap = ($urandom % 3 == 0);
            step(op, b, ap, -1, "R12");
        end
        step(0, 0, 0, 0, "R11");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule